// File: doc/BRIEF.md
# Trap and Interrupt Request Register

This block keeps two pending conditions of a processor core side by side in a single 8-bit word. The low five bits hold the level of the highest interrupt request that an external evaluator has found. The upper three bits hold the code of a pending arithmetic trap. Execution logic writes trap codes when an instruction overflows, divides by zero or indexes out of range, and clears them once the trap has been taken. The interrupt evaluator refreshes the level whenever its inputs change.

Each of the three update strobes writes only its own field, and the other field keeps its value. A trap set and a level update may arrive in the same cycle, and each lands in its own field. When a trap set and a trap clear arrive together, the set wins. The packed word and its decoded parts are all registered. A trap-pending flag is raised whenever the trap field is nonzero. Choosing between interrupt priorities and dispatching to vectors are left to other blocks.

Each field register is a small action machine. For the trap field the actions are TACT_KEEP (no strobe), TACT_LOAD (set strobe, taken even when clear is also high) and TACT_ZERO (clear strobe without set). For the level field the actions are LACT_KEEP (no strobe) and LACT_LOAD (update strobe). Every cycle goes back through this choice, and there is no other sequencing.

Top module: `tirq_reg`

## Requirements
- R1: While rst_n is low, and after it rises, both fields are zero, so tir_word, req_level, trap_code and trap_pending are all 0.
- R2: tir_word bits 4:0 carry the request level and bits 7:5 carry the trap code.
- R3: A cycle with trap_set high loads trap_code_in into the trap field on that clock edge. The level field is not changed unless lvl_upd is also high.
- R4: A cycle with trap_clr high and trap_set low zeroes the trap field. The level field is not changed unless lvl_upd is also high.
- R5: A cycle with lvl_upd high loads lvl_in into the level field. The trap field is not changed unless trap_set or trap_clr is also high.
- R6: When trap_set and trap_clr are both high in one cycle, the trap field takes trap_code_in.
- R7: trap_pending is 1 exactly when the trap field is nonzero.
- R8: A level update in the same cycle as a trap set or a trap clear applies both changes, each to its own field.
- R9: The trap codes are 1 for integer overflow, 2 for divide by zero and 7 for subscript range. Each is stored and reported unchanged.
- R10: In a cycle with no strobe, both fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_set | input | 1 | Load trap_code_in into the trap field |
| trap_code_in | input | 3 | Trap code to load |
| trap_clr | input | 1 | Zero the trap field |
| lvl_upd | input | 1 | Load lvl_in into the level field |
| lvl_in | input | 5 | Newly evaluated request level |
| tir_word | output | 8 | Packed word: trap code in bits 7:5, level in bits 4:0 |
| req_level | output | 5 | Current request level |
| trap_code | output | 3 | Current trap code |
| trap_pending | output | 1 | High when the trap code is nonzero |

## Verification
The bench builds the block with its default widths: a 5-bit level and a 3-bit code. This makes the full 8-bit layout observable, including the extreme level 31 and the top code 7 sitting next to each other in one word. With these widths every field boundary can be checked at the packed output. Every pairing of strobes that matters is exercised: set with clear, set with update, clear with update, and idle cycles. A reset in the middle of a run confirms that both fields return to zero.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    localparam int LVL_W_DEF  = 5;
    localparam int CODE_W_DEF = 3;

    // Trap codes carried in the upper field (R9)
    localparam logic [2:0] TRAP_INT_OVF   = 3'd1;
    localparam logic [2:0] TRAP_DIV_ZERO  = 3'd2;
    localparam logic [2:0] TRAP_SUBSCRIPT = 3'd7;

    typedef enum logic [1:0] {
        TACT_KEEP = 2'd0,
        TACT_LOAD = 2'd1,
        TACT_ZERO = 2'd2
    } trap_act_e;

    typedef enum logic {
        LACT_KEEP = 1'b0,
        LACT_LOAD = 1'b1
    } lvl_act_e;

endpackage

// File: rtl/tirq_trap_field.sv
module tirq_trap_field
    import tirq_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);

    trap_act_e         act;
    logic [CODE_W-1:0] code_q;

    // Action choice: a set outranks a clear in the same cycle (R6)
    always_comb begin
        if (set_i)      act = TACT_LOAD;
        else if (clr_i) act = TACT_ZERO;
        else            act = TACT_KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            unique case (act)
                TACT_LOAD: code_q <= code_i;
                TACT_ZERO: code_q <= '0;
                TACT_KEEP: code_q <= code_q;
                default:   code_q <= code_q;
            endcase
        end
    end

    always_comb code_o = code_q;

endmodule

// File: rtl/tirq_level_field.sv
module tirq_level_field
    import tirq_pkg::*;
#(
    parameter int LVL_W = LVL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic [LVL_W-1:0] lvl_o
);

    lvl_act_e         act;
    logic [LVL_W-1:0] lvl_q;

    always_comb act = upd_i ? LACT_LOAD : LACT_KEEP;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            unique case (act)
                LACT_LOAD: lvl_q <= lvl_i;
                LACT_KEEP: lvl_q <= lvl_q;
                default:   lvl_q <= lvl_q;
            endcase
        end
    end

    always_comb lvl_o = lvl_q;

endmodule

// File: rtl/tirq_pack.sv
module tirq_pack
    import tirq_pkg::*;
#(
    parameter int LVL_W  = LVL_W_DEF,
    parameter int CODE_W = CODE_W_DEF,
    localparam int WORD_W = LVL_W + CODE_W
) (
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [WORD_W-1:0] word_o,
    output logic [LVL_W-1:0]  lvl_o,
    output logic [CODE_W-1:0] code_o,
    output logic              pending_o
);

    // Level in the low bits, trap code above it (R2)
    always_comb begin
        word_o    = {code_i, lvl_i};
        lvl_o     = word_o[LVL_W-1:0];
        code_o    = word_o[WORD_W-1:LVL_W];
        pending_o = |code_o;
    end

endmodule

// File: rtl/tirq_reg.sv
module tirq_reg
    import tirq_pkg::*;
#(
    parameter int LVL_W  = LVL_W_DEF,
    parameter int CODE_W = CODE_W_DEF,
    localparam int WORD_W = LVL_W + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_set,
    input  logic [CODE_W-1:0] trap_code_in,
    input  logic              trap_clr,
    input  logic              lvl_upd,
    input  logic [LVL_W-1:0]  lvl_in,
    output logic [WORD_W-1:0] tir_word,
    output logic [LVL_W-1:0]  req_level,
    output logic [CODE_W-1:0] trap_code,
    output logic              trap_pending
);

    logic [CODE_W-1:0] code_q;
    logic [LVL_W-1:0]  lvl_q;

    tirq_trap_field #(.CODE_W(CODE_W)) u_trap (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (trap_set),
        .clr_i  (trap_clr),
        .code_i (trap_code_in),
        .code_o (code_q)
    );

    tirq_level_field #(.LVL_W(LVL_W)) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .upd_i (lvl_upd),
        .lvl_i (lvl_in),
        .lvl_o (lvl_q)
    );

    tirq_pack #(.LVL_W(LVL_W), .CODE_W(CODE_W)) u_pack (
        .lvl_i     (lvl_q),
        .code_i    (code_q),
        .word_o    (tir_word),
        .lvl_o     (req_level),
        .code_o    (trap_code),
        .pending_o (trap_pending)
    );

endmodule

// File: rtl/tirq_reg_chk.sv
module tirq_reg_chk #(
    parameter int LVL_W  = 5,
    parameter int CODE_W = 3,
    localparam int WORD_W = LVL_W + CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_set,
    input logic [CODE_W-1:0] trap_code_in,
    input logic              trap_clr,
    input logic              lvl_upd,
    input logic [LVL_W-1:0]  lvl_in,
    input logic [WORD_W-1:0] tir_word,
    input logic [LVL_W-1:0]  req_level,
    input logic [CODE_W-1:0] trap_code,
    input logic              trap_pending
);

    a_r3_set_loads_code: assert property (@(posedge clk) disable iff (!rst_n)
        trap_set |=> trap_code == $past(trap_code_in));

    a_r3_set_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_set && !lvl_upd) |=> $stable(req_level));

    a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_clr && !trap_set) |=> trap_code == '0);

    a_r4_clear_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_clr && !lvl_upd) |=> $stable(req_level));

    a_r5_level_loads: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_upd |=> req_level == $past(lvl_in));

    a_r5_level_keeps_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_upd && !trap_set && !trap_clr) |=> $stable(trap_code));

    a_r7_pending_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pending == (trap_code != '0));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_set && !trap_clr && !lvl_upd) |=> $stable(tir_word));

endmodule

bind tirq_reg tirq_reg_chk #(.LVL_W(LVL_W), .CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_set     (trap_set),
    .trap_code_in (trap_code_in),
    .trap_clr     (trap_clr),
    .lvl_upd      (lvl_upd),
    .lvl_in       (lvl_in),
    .tir_word     (tir_word),
    .req_level    (req_level),
    .trap_code    (trap_code),
    .trap_pending (trap_pending)
);

// File: tb/tirq_reg_tb.sv
`timescale 1ns/1ps
module tirq_reg_tb;
    import tirq_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       trap_set;
    logic [2:0] trap_code_in;
    logic       trap_clr;
    logic       lvl_upd;
    logic [4:0] lvl_in;
    logic [7:0] tir_word;
    logic [4:0] req_level;
    logic [2:0] trap_code;
    logic       trap_pending;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tirq_reg u_dut (
        .clk(clk), .rst_n(rst_n),
        .trap_set(trap_set), .trap_code_in(trap_code_in), .trap_clr(trap_clr),
        .lvl_upd(lvl_upd), .lvl_in(lvl_in),
        .tir_word(tir_word), .req_level(req_level),
        .trap_code(trap_code), .trap_pending(trap_pending)
    );

    // Vector: {set, code[2:0], clr, upd, lvl[4:0], expected word[7:0]}
    localparam int NV = 10;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 3'd1, 1'b0, 1'b0, 5'd0,  8'h20},  // R3 R9 integer overflow
        {1'b0, 3'd0, 1'b0, 1'b1, 5'd31, 8'h3F},  // R5 top level
        {1'b1, 3'd2, 1'b0, 1'b0, 5'd0,  8'h5F},  // R3 R9 divide by zero
        {1'b0, 3'd0, 1'b1, 1'b0, 5'd0,  8'h1F},  // R4 clear keeps level
        {1'b1, 3'd7, 1'b1, 1'b0, 5'd0,  8'hFF},  // R6 R9 set beats clear
        {1'b0, 3'd0, 1'b1, 1'b1, 5'd3,  8'h03},  // R8 clear with update
        {1'b0, 3'd5, 1'b0, 1'b0, 5'd9,  8'h03},  // R10 idle
        {1'b1, 3'd1, 1'b0, 1'b1, 5'd16, 8'h30},  // R8 set with update
        {1'b0, 3'd0, 1'b0, 1'b1, 5'd0,  8'h20},  // R5 level to zero
        {1'b0, 3'd0, 1'b1, 1'b0, 5'd0,  8'h00}   // R4 clear
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [7:0] exp);
        check({req, " word (R2)"}, int'(tir_word), int'(exp));
        check({req, " level"}, int'(req_level), int'(exp[4:0]));
        check({req, " code"}, int'(trap_code), int'(exp[7:5]));
        check({req, " pending (R7)"}, int'(trap_pending), int'(exp[7:5] != 3'd0));
    endtask

    task automatic drive(input logic s, input logic [2:0] c, input logic cl,
                         input logic u, input logic [4:0] l);
        @(negedge clk);
        trap_set = s; trap_code_in = c; trap_clr = cl; lvl_upd = u; lvl_in = l;
        @(posedge clk);
        #1;
        trap_set = 1'b0; trap_clr = 1'b0; lvl_upd = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; trap_set = 1'b0; trap_code_in = '0; trap_clr = 1'b0;
        lvl_upd = 1'b0; lvl_in = '0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset", 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][18], VEC[i][17:15], VEC[i][14], VEC[i][13], VEC[i][12:8]);
            check_all($sformatf("vector %0d", i), VEC[i][7:0]);
        end

        // R9 subscript range code alone
        drive(1'b1, TRAP_SUBSCRIPT, 1'b0, 1'b0, 5'd0);
        check("R9 subscript code", int'(trap_code), 7);
        drive(1'b1, TRAP_DIV_ZERO, 1'b0, 1'b0, 5'd0);
        check("R9 divide code", int'(trap_code), 2);
        drive(1'b1, TRAP_INT_OVF, 1'b0, 1'b0, 5'd0);
        check("R9 overflow code", int'(trap_code), 1);

        // R1 reset from a loaded state
        drive(1'b1, 3'd7, 1'b0, 1'b1, 5'd21);
        check_all("R3 R5 preload", 8'hF5);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_all("R1 mid reset", 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 3'd0, 1'b0, 1'b0, 5'd0);
        check_all("R1 after reset", 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule